// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits between an 8-bit console's buses and the memories on a game cartridge. Register writes land in the upper half of the CPU address space and are captured on the clock edge. From them the block forms two translations. A CPU read address in 0x8000-0xFFFF becomes an offset into program ROM, built from four 8 KB windows. A picture-bus address in 0x0000-0x1FFF becomes an offset into character memory, built from eight 1 KB slots.

It also gates CPU writes to the 8 KB work RAM at 0x6000-0x7FFF, and it drives the nametable mirroring select. Two bits of the select register permute the mapping. One swaps the position of the second-last fixed program bank. The other exchanges the two paired 2 KB character regions with the four single 1 KB regions.

Translation is purely combinational from the current register contents. Bank counts are powers of two, so out-of-range bank numbers wrap by masking.

Top module: `cart_bank_map`

## Requirements
- R1: A CPU write (cpu_we high at a clock edge) to 0x8000-0x9FFF with address bit 0 clear loads the 8-bit select register. With bit 0 set it loads bank register number select[2:0].
- R2: After reset the bank registers hold 0,2,4,5,6,7,0,1 for registers 0..7 and the select register is 0. Mirroring is vertical and work RAM is enabled and unprotected.
- R3: With select bit 6 clear, the program windows at 0x8000, 0xA000, 0xC000 and 0xE000 use register 6, register 7, bank PRG_BANKS-2 and bank PRG_BANKS-1. prg_rom_addr is {bank, cpu_addr[12:0]}.
- R4: With select bit 6 set, the windows use bank PRG_BANKS-2, register 7, register 6 and bank PRG_BANKS-1.
- R5: With select bit 7 clear, character slots 0..7 (ppu_addr[12:10]) use: register 0 with bit 0 cleared, that value plus 1, register 1 with bit 0 cleared, that value plus 1, then registers 2, 3, 4 and 5. chr_addr is {bank, ppu_addr[9:0]}.
- R6: With select bit 7 set, slots 0..3 use registers 2..5 and slots 4..7 use the register 0 and register 1 pairs as in R5.
- R7: Every bank number is reduced modulo the bank count by keeping its low log2(count) bits.
- R8: A write to 0xA000-0xBFFF with bit 0 clear sets mirror_mode from data bit 0. Data bit 0 = 0 gives mirror_mode 0 (vertical) and data bit 0 = 1 gives mirror_mode 1 (horizontal). mirror_mode changes on no other write.
- R9: With FOUR_SCREEN set, mirror_mode is always 2 and the R8 write is ignored.
- R10: A write to 0xA000-0xBFFF with bit 0 set takes data bit 7 as RAM enable and bit 6 as write protect. wram_we is high only for cpu_we to 0x6000-0x7FFF while the RAM is enabled and not protected.
- R11: chr_we follows ppu_we for addresses below 0x2000 only when CHR_IS_RAM is set. With character ROM it stays low.
- R12: Writes to 0xC000-0xFFFF change no mapping register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | Picture-bus address |
| ppu_we | input | 1 | Picture-bus write strobe |
| prg_rom_addr | output | log2(PRG_BANKS)+13 | Program ROM byte offset |
| wram_we | output | 1 | Work RAM write enable |
| chr_addr | output | log2(CHR_BANKS)+10 | Character memory byte offset |
| chr_we | output | 1 | Character RAM write enable |
| mirror_mode | output | 2 | 0 vertical, 1 horizontal, 2 four-screen |

## Verification
A vector table selects a register, loads it and probes one window. It covers both program modes and both character orders. Odd values are written into the paired registers, which separates a mapper that clears bit 0 from one that does not. Values above the bank count expose missing wrap masks. A probe of a window fed by a register other than the one just written shows whether the select field steered the load. Directed sequences add the reset map across all eight slots, the RAM enable/protect combinations, the mirroring writes on a normal and a four-screen instance, and character writes on ROM and RAM builds.

// File: rtl/cart_bank_map.sv
module cart_bank_map #(
  parameter int PRG_BANKS   = 32,
  parameter int CHR_BANKS   = 128,
  parameter bit FOUR_SCREEN = 1'b0,
  parameter bit CHR_IS_RAM  = 1'b0,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_data,
  input  logic               cpu_we,
  input  logic [13:0]        ppu_addr,
  input  logic               ppu_we,
  output logic [PRG_W+12:0]  prg_rom_addr,
  output logic               wram_we,
  output logic [CHR_W+9:0]   chr_addr,
  output logic               chr_we,
  output logic [1:0]         mirror_mode
);
  localparam logic [PRG_W-1:0] LAST   = PRG_W'(PRG_BANKS - 1);
  localparam logic [PRG_W-1:0] SECOND = PRG_W'(PRG_BANKS - 2);

  logic [7:0] sel;
  logic [7:0] bank [8];
  logic       ram_en, ram_wp, mir_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= 8'd0;
      bank[0] <= 8'd0;
      bank[1] <= 8'd2;
      bank[2] <= 8'd4;
      bank[3] <= 8'd5;
      bank[4] <= 8'd6;
      bank[5] <= 8'd7;
      bank[6] <= 8'd0;
      bank[7] <= 8'd1;
      ram_en  <= 1'b1;
      ram_wp  <= 1'b0;
      mir_h   <= 1'b0;
    end else if (cpu_we && cpu_addr[15:14] == 2'b10) begin
      if (!cpu_addr[13]) begin
        if (cpu_addr[0]) bank[sel[2:0]] <= cpu_data;
        else             sel <= cpu_data;
      end else begin
        if (cpu_addr[0])       {ram_en, ram_wp} <= cpu_data[7:6];
        else if (!FOUR_SCREEN) mir_h <= cpu_data[0];
      end
    end
  end

  logic [PRG_W-1:0] pnum;
  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    pnum = sel[6] ? SECOND : bank[6][PRG_W-1:0];
      2'd1:    pnum = bank[7][PRG_W-1:0];
      2'd2:    pnum = sel[6] ? bank[6][PRG_W-1:0] : SECOND;
      default: pnum = LAST;
    endcase
  end
  assign prg_rom_addr = {pnum, cpu_addr[12:0]};

  logic [2:0] cslot;
  logic [7:0] cnum;
  assign cslot = ppu_addr[12:10] ^ {sel[7], 2'b00};
  assign cnum  = cslot[2] ? bank[3'd2 + {1'b0, cslot[1:0]}]
                          : {bank[{2'b00, cslot[1]}][7:1], cslot[0]};
  assign chr_addr = {cnum[CHR_W-1:0], ppu_addr[9:0]};

  assign wram_we     = cpu_we && cpu_addr[15:13] == 3'b011 && ram_en && !ram_wp;
  assign chr_we      = CHR_IS_RAM && ppu_we && !ppu_addr[13];
  assign mirror_mode = FOUR_SCREEN ? 2'd2 : {1'b0, mir_h};

  logic unused_bits;
  assign unused_bits = ^{bank[0], bank[1], bank[2], bank[3], bank[4], bank[5],
                         bank[6], bank[7], sel[5:3], cnum};
endmodule

module cart_bank_map_chk #(
  parameter int PRG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cpu_win,
  input logic             cpu_a0,
  input logic             cpu_we,
  input logic             ppu_a13,
  input logic             ppu_we,
  input logic [PRG_W+12:0] prg_rom_addr,
  input logic             wram_we,
  input logic             chr_we,
  input logic [1:0]       mirror_mode
);
  p_wram_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> (cpu_we && cpu_win == 3'b011));

  p_last_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_win == 3'b111 |-> prg_rom_addr[PRG_W+12:13] == {PRG_W{1'b1}});

  p_chr_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> (ppu_we && !ppu_a13));

  p_mirror_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_win == 3'b101 && !cpu_a0) |=> $stable(mirror_mode));

  p_mirror_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_mode != 2'd3);
endmodule

bind cart_bank_map cart_bank_map_chk #(.PRG_W(PRG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_win(cpu_addr[15:13]), .cpu_a0(cpu_addr[0]),
  .cpu_we(cpu_we), .ppu_a13(ppu_addr[13]), .ppu_we(ppu_we),
  .prg_rom_addr(prg_rom_addr), .wram_we(wram_we), .chr_we(chr_we),
  .mirror_mode(mirror_mode)
);

// File: tb/sim_cart_bank_map.sv
module sim_cart_bank_map;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_we = 1'b0;
  logic [13:0] ppu_addr = 14'h0000;
  logic        ppu_we = 1'b0;
  logic [17:0] prg0, prg1;
  logic [16:0] chr0, chr1;
  logic        wwe0, wwe1, cwe0, cwe1;
  logic [1:0]  mir0, mir1;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cart_bank_map u0 (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_we(cpu_we), .ppu_addr(ppu_addr), .ppu_we(ppu_we), .prg_rom_addr(prg0),
    .wram_we(wwe0), .chr_addr(chr0), .chr_we(cwe0), .mirror_mode(mir0));

  cart_bank_map #(.FOUR_SCREEN(1'b1), .CHR_IS_RAM(1'b1)) u1 (.clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_we(cpu_we), .ppu_addr(ppu_addr),
    .ppu_we(ppu_we), .prg_rom_addr(prg1), .wram_we(wwe1), .chr_addr(chr1),
    .chr_we(cwe1), .mirror_mode(mir1));

  // {write addr, write data, probe addr, expected bank, probe is character}
  localparam logic [48:0] VEC [17] = '{
    {16'h8000, 8'h06, 16'h8000, 8'd0,    1'b0},  // R1 R3
    {16'h8001, 8'h25, 16'h8000, 8'd5,    1'b0},  // R1 R7
    {16'h8000, 8'h07, 16'hA000, 8'd1,    1'b0},  // R3
    {16'h8001, 8'h0A, 16'hA000, 8'd10,   1'b0},  // R1
    {16'h8000, 8'h47, 16'h8000, 8'd30,   1'b0},  // R4
    {16'h8000, 8'h46, 16'hC000, 8'd5,    1'b0},  // R4
    {16'h8000, 8'h40, 16'hE000, 8'd31,   1'b0},  // R4
    {16'h8001, 8'h13, 16'h0000, 8'h12,   1'b1},  // R5
    {16'h8000, 8'h40, 16'h0400, 8'h13,   1'b1},  // R5
    {16'h8000, 8'h82, 16'h1000, 8'h12,   1'b1},  // R6
    {16'h8001, 8'h9C, 16'h0000, 8'h1C,   1'b1},  // R6 R7
    {16'h8000, 8'h02, 16'h1000, 8'h1C,   1'b1},  // R5
    {16'h8000, 8'h05, 16'h1C00, 8'd7,    1'b1},  // R5
    {16'hC000, 8'h55, 16'h1C00, 8'd7,    1'b1},  // R12
    {16'hE001, 8'h00, 16'h8000, 8'd5,    1'b0},  // R12
    {16'h8000, 8'h81, 16'h1800, 8'd2,    1'b1},  // R6
    {16'h8001, 8'hFF, 16'h1C00, 8'h7F,   1'b1}   // R6 R7
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic probe_prg(input logic [15:0] a, input logic [4:0] b, input string tag);
    @(negedge clk);
    cpu_addr = a;
    #1;
    chk(prg0 == {b, a[12:0]}, tag, prg0, {b, a[12:0]});
  endtask

  task automatic probe_chr(input logic [13:0] a, input logic [6:0] b, input string tag);
    @(negedge clk);
    ppu_addr = a;
    #1;
    chk(chr0 == {b, a[9:0]}, tag, chr0, {b, a[9:0]});
  endtask

  task automatic probe_wram(input logic [15:0] a, input bit exp, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b1;
    #1;
    chk(wwe0 == exp, tag, wwe0, exp);
    cpu_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset map
    probe_prg(16'h8000, 5'd0, "R2 win0");
    probe_prg(16'hA000, 5'd1, "R2 win1");
    probe_prg(16'hC000, 5'd30, "R2 win2");
    probe_prg(16'hE000, 5'd31, "R2 win3");
    for (int s = 0; s < 8; s++) probe_chr(14'(s * 1024 + 5), 7'(s), "R2 chr slot");
    #1 chk(mir0 == 2'd0, "R2 mirror", mir0, 0);
    probe_wram(16'h6123, 1'b1, "R2 wram enabled");

    for (int i = 0; i < 17; i++) begin
      wr(VEC[i][48:33], VEC[i][32:25]);
      if (VEC[i][0]) probe_chr(VEC[i][22:9], VEC[i][7:1], $sformatf("R1/R3-R7/R12 vec %0d", i));
      else           probe_prg(VEC[i][24:9], VEC[i][5:1], $sformatf("R1/R3-R7/R12 vec %0d", i));
    end

    // R8 / R9 mirroring
    wr(16'hA000, 8'h01);
    #1 chk(mir0 == 2'd1, "R8 horizontal", mir0, 1);
    chk(mir1 == 2'd2, "R9 four-screen held", mir1, 2);
    wr(16'hA002, 8'hFE);
    #1 chk(mir0 == 2'd0, "R8 vertical", mir0, 0);
    wr(16'hA001, 8'h81);
    #1 chk(mir0 == 2'd0, "R8 ram write leaves mirror", mir0, 0);

    // R10 RAM gating
    wr(16'hA001, 8'hC0);
    probe_wram(16'h7FFF, 1'b0, "R10 protected");
    wr(16'hA001, 8'h00);
    probe_wram(16'h6000, 1'b0, "R10 disabled");
    wr(16'hA001, 8'h80);
    probe_wram(16'h6000, 1'b1, "R10 enabled");
    probe_wram(16'h8000, 1'b0, "R10 outside window");

    // R11 character writes
    @(negedge clk);
    ppu_addr = 14'h0800; ppu_we = 1'b1;
    #1;
    chk(cwe0 == 1'b0, "R11 rom discards", cwe0, 0);
    chk(cwe1 == 1'b1, "R11 ram accepts", cwe1, 1);
    ppu_addr = 14'h2000;
    #1;
    chk(cwe1 == 1'b0, "R11 above pattern space", cwe1, 0);
    ppu_we = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule